// File: doc/BRIEF.md
# Sixteen-Channel External Interrupt Detector

This block watches sixteen asynchronous interrupt pins and turns activity on them into sticky request flags. Every pin is first brought into the clock domain through a two-stage synchronizer. A per-channel sense setting then decides which activity counts as a request: a low level, a falling edge, a rising edge, or either edge. On channels 2 to 15, a per-channel select bit chooses whether the primary pin or an alternate pin drives the detector. Channels 0 and 1 always use their primary pin.

Each channel holds its request in a two-state machine. The states are `CH_IDLE` (no request held) and `CH_PEND` (request held). The machine moves from `CH_IDLE` to `CH_PEND` on a detection. It moves from `CH_PEND` back to `CH_IDLE` on a clear, but only when no detection arrives in the same cycle. In every other case it stays where it is. A channel drives its request output only while its enable bit is set and its state is `CH_PEND`.

Software reaches the block through a small register port. It can program the enables, the sense modes and the pin selects, and it can read the flags. A flag is cleared by reading it as 1 and then writing 0 to that bit.

Top module: `exti_detect16`

## Requirements
- R1: After reset, all flags read 0, all enables are 0, every sense field is 01 (falling edge), all select bits are 0 and `irq_out` is 0.
- R2: The register map is selected by `addr`: 0 holds the enables (bit i for channel i); 1 holds the sense fields (bits 2i+1:2i for channel i); 2 holds the selects; 3 holds the flags. `rdata` shows the addressed register in the same cycle, and written values read back unchanged.
- R3: With sense code 01, a falling edge on the selected pin sets the channel's flag. The flag is visible no later than the third clock edge after the pin changes.
- R4: With sense code 10, a rising edge sets the flag and a falling edge does not.
- R5: With sense code 11, both a falling edge and a rising edge set the flag.
- R6: With sense code 00, the flag is set on every cycle in which the synchronized pin is low. A clear made while the pin is still low therefore leaves the flag set.
- R7: A flag stays set until it is cleared. Writing 0 to address 3 clears only those bits that read as 1 at the most recent read of address 3. Writing 1, or writing 0 to a bit not read as 1, has no effect.
- R8: When a clear and a new detection hit a channel in the same cycle, the flag stays set.
- R9: `irq_out[i]` is 1 exactly when enable bit i and flag i are both 1. The enable has no effect on whether the flag is set.
- R10: Select bit i (i from 2 to 15) set to 1 routes `pin_alt[i-2]` to channel i; set to 0 it routes `pin_pri[i]`. Select bits 0 and 1 always read 0, and channels 0 and 1 always use `pin_pri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| pin_pri | input | 16 | Primary interrupt pins, one per channel |
| pin_alt | input | 14 | Alternate pins for channels 2 to 15 |
| irq_out | output | 16 | Per-channel request, flag gated by enable |

## Verification
The bench builds the block with its default parameters: sixteen channels, alternates from channel 2 upward, and two synchronizer stages. At that size it can sweep every sense code across every channel, with a falling and a rising edge on each. The one-cycle overlap of a clear write with a fresh edge is placed exactly on the detection edge, so the detection-over-clear priority is observed directly. The alternate routing is exercised on one alternate-capable channel and on one fixed channel.

// File: rtl/exti_pkg.sv
package exti_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_t;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_t;

    localparam logic [1:0] REG_ENABLE = 2'd0;
    localparam logic [1:0] REG_SENSE  = 2'd1;
    localparam logic [1:0] REG_SELECT = 2'd2;
    localparam logic [1:0] REG_FLAGS  = 2'd3;

endpackage

// File: rtl/exti_sense.sv
module exti_sense
    import exti_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin,
    input  sense_t mode,
    output logic   hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    // Idle-high reset so no false falling edge appears after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur = sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (mode)
            SENSE_LOW:  hit = ~cur;
            SENSE_FALL: hit = prev_q & ~cur;
            SENSE_RISE: hit = ~prev_q & cur;
            SENSE_BOTH: hit = prev_q ^ cur;
        endcase
    end

endmodule

// File: rtl/exti_flag.sv
module exti_flag
    import exti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pend
);

    chan_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (hit)         state_d = CH_PEND;
            CH_PEND: if (clr && !hit) state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == CH_PEND);
    end

    assert_detect_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);

    assert_hold_until_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    assert_detect_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> pend);

    assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !hit) |=> !pend);

endmodule

// File: rtl/exti_regfile.sv
module exti_regfile
    import exti_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int ALT_FIRST = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             addr,
    input  logic [2*NUM_CH-1:0]    wdata,
    output logic [2*NUM_CH-1:0]    rdata,
    input  logic [NUM_CH-1:0]      flags,
    output logic [NUM_CH-1:0]      enable,
    output logic [2*NUM_CH-1:0]    sense,
    output logic [NUM_CH-1:ALT_FIRST] select,
    output logic [NUM_CH-1:0]      clr
);

    localparam int DW = 2 * NUM_CH;

    logic [NUM_CH-1:0] armed_q;

    always_comb begin
        clr = '0;
        if (wr_en && addr == REG_FLAGS) clr = armed_q & ~wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable  <= '0;
            sense   <= {NUM_CH{SENSE_FALL}};
            select  <= '0;
            armed_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    REG_ENABLE: enable <= wdata[NUM_CH-1:0];
                    REG_SENSE:  sense  <= wdata;
                    REG_SELECT: select <= wdata[NUM_CH-1:ALT_FIRST];
                    REG_FLAGS:  armed_q <= armed_q & ~clr;
                endcase
            end
            if (rd_en && addr == REG_FLAGS) armed_q <= flags;
        end
    end

    always_comb begin
        unique case (addr)
            REG_ENABLE: rdata = {{(DW-NUM_CH){1'b0}}, enable};
            REG_SENSE:  rdata = sense;
            REG_SELECT: rdata = {{(DW-NUM_CH){1'b0}}, select, {ALT_FIRST{1'b0}}};
            REG_FLAGS:  rdata = {{(DW-NUM_CH){1'b0}}, flags};
        endcase
    end

    assert_clear_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_FLAGS && !$past(rd_en && addr == REG_FLAGS) && $past(flags) == '0 && $past(armed_q) == '0)
        |-> clr == '0);

endmodule

// File: rtl/exti_detect16.sv
module exti_detect16
    import exti_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int ALT_FIRST   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [1:0]                    addr,
    input  logic [2*NUM_CH-1:0]           wdata,
    output logic [2*NUM_CH-1:0]           rdata,
    input  logic [NUM_CH-1:0]             pin_pri,
    input  logic [NUM_CH-ALT_FIRST-1:0]   pin_alt,
    output logic [NUM_CH-1:0]             irq_out
);

    logic [NUM_CH-1:0]          enable;
    logic [2*NUM_CH-1:0]        sense;
    logic [NUM_CH-1:ALT_FIRST]  select;
    logic [NUM_CH-1:0]          clr;
    logic [NUM_CH-1:0]          flags;
    logic [NUM_CH-1:0]          raw_pin;
    logic [NUM_CH-1:0]          hit;

    exti_regfile #(.NUM_CH(NUM_CH), .ALT_FIRST(ALT_FIRST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .flags  (flags),
        .enable (enable),
        .sense  (sense),
        .select (select),
        .clr    (clr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i >= ALT_FIRST) begin : g_mux
            assign raw_pin[i] = select[i] ? pin_alt[i-ALT_FIRST] : pin_pri[i];
        end else begin : g_fixed
            assign raw_pin[i] = pin_pri[i];
        end

        exti_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (raw_pin[i]),
            .mode  (sense_t'(sense[2*i+1 -: 2])),
            .hit   (hit[i])
        );

        exti_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[i]),
            .clr   (clr[i]),
            .pend  (flags[i])
        );
    end

    assign irq_out = enable & flags;

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~enable) == '0);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~flags) == '0);

endmodule

// File: tb/test_exti_detect16.sv
module test_exti_detect16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pin_pri = 16'hFFFF;
    logic [13:0] pin_alt = 14'h3FFF;
    logic [15:0] irq_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    exti_detect16 i_exti_detect16 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_pri(pin_pri), .pin_alt(pin_alt),
        .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_all();
        logic [31:0] tmp;
        rd(2'd3, tmp);
        wr(2'd3, 32'h0);
    endtask

    task automatic pulse_pri(input int ch);
        pin_pri[ch] = 1'b0; idle(4);
        pin_pri[ch] = 1'b1; idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 irq", {16'h0, irq_out}, 32'h0);
        rd(2'd0, d); check("R1 enable", d, 32'h0);
        rd(2'd1, d); check("R1 sense", d, 32'h5555_5555);
        rd(2'd2, d); check("R1 select", d, 32'h0);
        rd(2'd3, d); check("R1 flags", d, 32'h0);

        // R2 register readback
        wr(2'd0, 32'h0000_A5C3); rd(2'd0, d); check("R2 enable", d, 32'h0000_A5C3);
        wr(2'd1, 32'h1234_5678); rd(2'd1, d); check("R2 sense", d, 32'h1234_5678);
        // R10 select bits 0,1 not writable
        wr(2'd2, 32'h0000_FFFF); rd(2'd2, d); check("R10 select", d, 32'h0000_FFFC);
        wr(2'd2, 32'h0); wr(2'd0, 32'h0);

        // Sweep all sense codes over all channels (R3 R4 R5 R6 R7)
        for (int m = 0; m < 4; m++) begin
            string tag;
            logic [31:0] exp_fall;
            tag = (m == 0) ? "R6" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
            wr(2'd1, {16{m[1:0]}});
            idle(4);
            clear_all();
            for (int ch = 0; ch < 16; ch++) begin
                pin_pri[ch] = 1'b0; idle(4);
                rd(2'd3, d);
                exp_fall = (m == 2) ? 32'h0 : (32'h1 << ch);
                check({tag, " after fall"}, d, exp_fall);
                pin_pri[ch] = 1'b1; idle(4);
                rd(2'd3, d);
                check({tag, " after rise"}, d, 32'h1 << ch);
                wr(2'd3, 32'h0);
                rd(2'd3, d);
                check("R7 cleared", d, 32'h0);
            end
        end

        // R6 clear while still low leaves flag set
        wr(2'd1, 32'h0); idle(4); clear_all();
        pin_pri[3] = 1'b0; idle(4);
        clear_all(); idle(2);
        rd(2'd3, d); check("R6 low persists", d, 32'h8);
        pin_pri[3] = 1'b1; idle(4);
        clear_all();
        rd(2'd3, d); check("R6 cleared when high", d, 32'h0);

        // R7 clear needs prior read as 1; writing 1 has no effect
        wr(2'd1, 32'h5555_5555); idle(4); clear_all();
        pulse_pri(5);
        wr(2'd3, 32'h0);
        rd(2'd3, d); check("R7 unread zero-write", d, 32'h20);
        wr(2'd3, 32'hFFFF);
        rd(2'd3, d); check("R7 write one", d, 32'h20);
        wr(2'd3, 32'h0);
        rd(2'd3, d); check("R7 armed clear", d, 32'h0);

        // R8 detection wins over same-cycle clear
        pulse_pri(6);
        rd(2'd3, d); check("R8 setup", d, 32'h40);
        pin_pri[6] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(2'd3, 32'h0);
        rd(2'd3, d); check("R8 detect beats clear", d, 32'h40);
        pin_pri[6] = 1'b1; idle(4);
        wr(2'd3, 32'h0);
        rd(2'd3, d); check("R8 later clear", d, 32'h0);

        // R9 enable gating
        wr(2'd0, 32'h0000_00C0);
        pulse_pri(7); pulse_pri(8);
        rd(2'd3, d); check("R9 flags ungated", d, 32'h180);
        check("R9 irq", {16'h0, irq_out}, 32'h80);
        wr(2'd0, 32'h0);
        check("R9 irq off", {16'h0, irq_out}, 32'h0);
        clear_all();

        // R10 alternate routing
        wr(2'd2, 32'h0000_0200);
        idle(4);
        pulse_pri(9);
        rd(2'd3, d); check("R10 primary ignored", d, 32'h0);
        pin_alt[7] = 1'b0; idle(4); pin_alt[7] = 1'b1; idle(4);
        rd(2'd3, d); check("R10 alternate used", d, 32'h200);
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0000_0003);
        pulse_pri(0);
        rd(2'd3, d); check("R10 ch0 primary", d, 32'h1);
        clear_all();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule